// File: doc/BRIEF.md
# External Request Edge Detection Unit

This block serves a single external request channel. It chooses one of four candidate input lines, brings that line into the local clock domain, and looks for transitions on it. Rising and falling transitions can each be armed on their own. An armed transition sets a sticky request flag. An unarmed transition can optionally clear the flag, so the flag follows the level of the input instead of only latching an event.

When forwarding is switched on, every armed transition also sends a one-clock pulse to one of four trigger outputs. A pointer field picks the output. Software sets everything up by writing one configuration word. It reads the flag from a dedicated output and clears it with a one-cycle clear strobe.

Configuration word layout (`cfg_wdata`): bits [1:0] line select, bit 2 rising arm, bit 3 falling arm, bit 4 level mode, bit 5 trigger forward enable, bits [8:6] output pointer.

Top module: `ext_req_edge`

## Requirements
- R1: Field [1:0] of the configuration word picks the observed line: value k (0 to 3) makes `lines_i[k]` the channel input, and the other lines have no effect on the flag or the triggers.
- R2: With bit 2 set, a rising transition on the selected line sets `flag_o`. With bit 2 clear, a rising transition does not set it.
- R3: With bit 3 set, a falling transition on the selected line sets `flag_o`. With bit 3 clear, a falling transition does not set it.
- R4: With bit 4 set, a transition whose direction is not armed clears `flag_o`. With bit 4 clear, such a transition leaves `flag_o` unchanged.
- R5: With bit 5 clear, `trig_o` stays all zero while the flag still updates as configured. With bit 5 set, each armed transition produces a trigger.
- R6: Pointer bits [7:6] route the trigger: value m drives `trig_o[m]`. Bit 8 is ignored.
- R7: With the default two synchronizer stages, a change driven on the selected line shows up on `flag_o` and `trig_o` after the third rising clock edge. The trigger lasts exactly one cycle and is one-hot.
- R8: A one-cycle high on `flag_clr` clears `flag_o`. If an armed transition arrives in the same cycle, the set wins and the flag stays 1.
- R9: Writing a new line select never produces a transition by itself, even when the old and new lines sit at different levels.
- R10: While reset is asserted and right after it, `flag_o` is 0, `trig_o` is 0, and every configuration field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lines_i | input | 4 | Candidate request lines, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration word |
| flag_clr | input | 1 | Software clear of the request flag |
| flag_o | output | 1 | Sticky request flag |
| trig_o | output | 4 | One-hot trigger pulses, one line per output channel |

## Verification
The bench builds the block with its default of two synchronizer stages. That fixes the latency from input change to flag at three rising edges, so every check can sample one exact cycle. At that latency the bench can also put a software clear into the very cycle in which a detected transition is being registered, which tests the set-over-clear priority. Sweeping all four select values with the pointer's ignored top bit toggled covers the whole routing map.

// File: rtl/ext_req_edge.sv
module ext_req_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lines_i,
  input  logic       cfg_we,
  input  logic [8:0] cfg_wdata,
  input  logic       flag_clr,
  output logic       flag_o,
  output logic [3:0] trig_o
);

  localparam int NUM_LINES = 4;

  logic [NUM_LINES-1:0] synced;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], lines_i[g]};
    end
    assign synced[g] = chain_q[SYNC_STAGES-1];
  end

  logic [1:0] sel_q;
  logic       rise_en_q, fall_en_q, lvl_en_q, trig_en_q;
  logic [2:0] ptr_q;
  logic       prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      rise_en_q <= 1'b0;
      fall_en_q <= 1'b0;
      lvl_en_q  <= 1'b0;
      trig_en_q <= 1'b0;
      ptr_q     <= '0;
    end else if (cfg_we) begin
      sel_q     <= cfg_wdata[1:0];
      rise_en_q <= cfg_wdata[2];
      fall_en_q <= cfg_wdata[3];
      lvl_en_q  <= cfg_wdata[4];
      trig_en_q <= cfg_wdata[5];
      ptr_q     <= cfg_wdata[8:6];
    end
  end

  wire cur     = synced[sel_q];
  wire rise_ev = cur & ~prev_q;
  wire fall_ev = ~cur & prev_q;
  wire set_ev  = (rise_ev & rise_en_q) | (fall_ev & fall_en_q);
  wire clr_ev  = lvl_en_q & ((rise_ev & ~rise_en_q) | (fall_ev & ~fall_en_q));
  wire sel_chg = cfg_we && (cfg_wdata[1:0] != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_o <= 1'b0;
      trig_o <= '0;
    end else begin
      prev_q <= sel_chg ? synced[cfg_wdata[1:0]] : cur;
      if (set_ev)                 flag_o <= 1'b1;
      else if (clr_ev || flag_clr) flag_o <= 1'b0;
      trig_o <= (set_ev && trig_en_q) ? (4'b0001 << ptr_q[1:0]) : 4'b0000;
    end
  end

endmodule

// File: rtl/ext_req_edge_chk.sv
module ext_req_edge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_clr,
  input logic       flag_o,
  input logic [3:0] trig_o,
  input logic       trig_en,
  input logic       set_ev
);

  AST_TRIG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_o)); // R7

  AST_TRIG_MEANS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o != 4'b0000) |-> flag_o); // R8

  AST_NO_TRIG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |=> (trig_o == 4'b0000)); // R5

  AST_FLAG_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_ev)); // R2

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !set_ev) |=> !flag_o); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_o); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!flag_o && trig_o == 4'b0000)); // R10

endmodule

bind ext_req_edge ext_req_edge_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .flag_clr(flag_clr),
  .flag_o  (flag_o),
  .trig_o  (trig_o),
  .trig_en (trig_en_q),
  .set_ev  (set_ev)
);

// File: tb/test_ext_req_edge.sv
module test_ext_req_edge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] lines_i = '0;
  logic       cfg_we = 1'b0;
  logic [8:0] cfg_wdata = '0;
  logic       flag_clr = 1'b0;
  logic       flag_o;
  logic [3:0] trig_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ext_req_edge i_ext_req_edge (
    .clk(clk), .rst_n(rst_n), .lines_i(lines_i), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .flag_clr(flag_clr), .flag_o(flag_o), .trig_o(trig_o)
  );

  function automatic logic [8:0] mk(input logic [1:0] sel, input logic re, input logic fe,
                                    input logic lv, input logic te, input logic [2:0] ptr);
    return {ptr, te, lv, fe, re, sel};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic sw_clear();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    tick(2);
    chk("R10 flag in reset", {7'd0, flag_o}, 8'd0);
    chk("R10 trig in reset", {4'd0, trig_o}, 8'd0);
    rst_n = 1'b1;
    lines_i = 4'b0001;
    tick(4);
    chk("R10 no arm after reset", {7'd0, flag_o}, 8'd0);
    lines_i = 4'b0000;
    tick(4);
  endtask

  task automatic t_rise();
    wr(mk(2'd0, 1, 0, 0, 1, 3'd0));
    lines_i[0] = 1'b1;
    tick(2);
    chk("R7 flag not early", {7'd0, flag_o}, 8'd0);
    chk("R7 trig not early", {4'd0, trig_o}, 8'd0);
    tick(1);
    chk("R2 rise sets flag", {7'd0, flag_o}, 8'd1);
    chk("R7 trig on third edge", {4'd0, trig_o}, 8'h1);
    tick(1);
    chk("R7 trig single cycle", {4'd0, trig_o}, 8'h0);
    lines_i[0] = 1'b0;
    tick(4);
    chk("R3 disarmed fall no set / R4 level off keeps", {7'd0, flag_o}, 8'd1);
    sw_clear();
    chk("R8 sw clear", {7'd0, flag_o}, 8'd0);
    wr(mk(2'd0, 0, 0, 0, 1, 3'd0));
    lines_i[0] = 1'b1;
    tick(4);
    chk("R2 disarmed rise no set", {7'd0, flag_o}, 8'd0);
  endtask

  task automatic t_fall();
    wr(mk(2'd0, 0, 1, 0, 1, 3'b110));
    lines_i[0] = 1'b0;
    tick(3);
    chk("R3 fall sets flag", {7'd0, flag_o}, 8'd1);
    chk("R6 ptr 110 -> out2", {4'd0, trig_o}, 8'h4);
    tick(1);
    sw_clear();
  endtask

  task automatic t_level();
    wr(mk(2'd0, 1, 0, 1, 0, 3'd1));
    lines_i[0] = 1'b1;
    tick(3);
    chk("R5 flag still sets with forward off", {7'd0, flag_o}, 8'd1);
    chk("R5 no trig with forward off", {4'd0, trig_o}, 8'h0);
    lines_i[0] = 1'b0;
    tick(3);
    chk("R4 unarmed fall clears in level mode", {7'd0, flag_o}, 8'd0);
    chk("R5 no trig on clear", {4'd0, trig_o}, 8'h0);
  endtask

  task automatic t_select();
    for (int k = 0; k < 4; k++) begin
      lines_i = 4'b0000;
      tick(4);
      sw_clear();
      wr(mk(k[1:0], 1, 0, 0, 1, {k[0], k[1:0]}));
      lines_i = ~(4'b0001 << k);
      tick(4);
      chk($sformatf("R1 other lines ignored sel=%0d", k), {7'd0, flag_o}, 8'd0);
      lines_i = 4'b1111;
      tick(3);
      chk($sformatf("R1 selected line sets sel=%0d", k), {7'd0, flag_o}, 8'd1);
      chk($sformatf("R6 routing sel=%0d", k), {4'd0, trig_o}, 8'(4'b0001 << k));
      tick(1);
    end
    lines_i = 4'b0000;
    tick(4);
    sw_clear();
  endtask

  task automatic t_switch();
    lines_i = 4'b0010;
    wr(mk(2'd0, 1, 1, 0, 1, 3'd0));
    tick(4);
    sw_clear();
    wr(mk(2'd1, 1, 1, 0, 1, 3'd0));
    for (int i = 0; i < 4; i++) begin
      chk("R9 switch to high line no trig", {4'd0, trig_o}, 8'h0);
      tick(1);
    end
    chk("R9 switch to high line no flag", {7'd0, flag_o}, 8'd0);
    wr(mk(2'd0, 1, 1, 0, 1, 3'd0));
    for (int i = 0; i < 4; i++) begin
      chk("R9 switch to low line no trig", {4'd0, trig_o}, 8'h0);
      tick(1);
    end
    chk("R9 switch to low line no flag", {7'd0, flag_o}, 8'd0);
    lines_i = 4'b0000;
    tick(4);
  endtask

  task automatic t_priority();
    wr(mk(2'd0, 1, 0, 0, 0, 3'd0));
    lines_i[0] = 1'b1;
    tick(2);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk("R8 set wins over sw clear", {7'd0, flag_o}, 8'd1);
    sw_clear();
    chk("R8 later sw clear works", {7'd0, flag_o}, 8'd0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_level();
    t_select();
    t_switch();
    t_priority();
    finish_run();
  end
endmodule